// File: doc/BRIEF.md
# DMA Access Port with Snoop Filter

This block is the service unit through which a DMA engine reads and writes the on-chip level-two SRAM. Coherence with a level-one data cache is kept by snooping that cache before the SRAM is touched. A small history table remembers lines that were snooped recently and are known to be clean or absent in the level-one cache, so repeated snoops to the same lines are skipped. The level-one cache reports every fill or write of a line on a notification input, and that clears the line's history entry.

Addresses are in units of a line. A line is one SRAM word made of two DMA beats, with the low half sent first. A read burst covers four consecutive lines (eight beats) and a write burst covers two lines (four beats). The base line of a burst is aligned to its size. Read fetches go through a two-word buffer. The snoop and SRAM access for the next line therefore run while the beats of the current line drain to the DMA side, and the second beat of each word is served from the buffer rather than from a second bank access. On writes, beat pairs are merged into one SRAM word write. Snoop and SRAM responses both arrive in the cycle after the request.

Top module: `dma_snoop_port`

## Requirements
- R1: While reset is held and in the first cycle after it, reqReady is 1 and rdValid, wrReady, snpValid, sramRe and sramWe are 0.
- R2: A read burst accepted at base line B delivers exactly eight beats, for lines B..B+3 in ascending order, with bits 31:0 of each line word sent before bits 63:32.
- R3: A write burst accepted at base line B takes exactly four beats. Beats 0 and 1 form one SRAM write to line B as {beat1, beat0}, and beats 2 and 3 form one SRAM write to line B+1. No SRAM read takes place during the burst.
- R4: A snoop is issued for a burst line only when that line has no valid history entry. A line that was snooped gets a history entry. A snoop is never issued in the same cycle as an SRAM access.
- R5: The history holds the four most recently recorded lines, and a new record overwrites the oldest slot.
- R6: A level-one fill notification for a line clears that line's history entry, so the next burst touching the line snoops it again.
- R7: When a read snoop returns dirty, the beats of that line carry the snooped word. In the next cycle the same word is written to the same SRAM line, and that line gets no SRAM read.
- R8: A read burst makes exactly one SRAM access (a read or a write-back) per line, four in total, and never asserts a read and a write in the same cycle.
- R9: In a write burst, wrReady stays low and no SRAM write is issued until the snoop of the current line, if one is needed, has returned.
- R10: While rdValid is 1 and rdReady is 0, rdValid and rdData stay unchanged into the next cycle. No beat is dropped or repeated.
- R11: reqReady is low from the cycle after a request is accepted until every beat of that burst has been transferred. While reqReady is high, no beat is offered or accepted and no snoop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request valid |
| reqWrite | input | 1 | 1 selects a write burst, 0 selects a read burst |
| reqLine | input | LINE_AW | Aligned base line of the burst |
| reqReady | output | 1 | Port idle, request accepted when reqValid is also high |
| rdValid | output | 1 | Read beat valid |
| rdData | output | BEAT_W | Read beat data |
| rdReady | input | 1 | DMA side accepts the read beat |
| wrValid | input | 1 | Write beat valid |
| wrData | input | BEAT_W | Write beat data |
| wrReady | output | 1 | Port accepts the write beat |
| snpValid | output | 1 | Snoop request to level-one cache |
| snpLine | output | LINE_AW | Snooped line |
| snpDirty | input | 1 | Snoop result dirty, valid one cycle after snpValid |
| snpData | input | 2*BEAT_W | Snooped line word, valid with snpDirty |
| sramRe | output | 1 | SRAM read strobe |
| sramWe | output | 1 | SRAM write strobe |
| sramAddr | output | LINE_AW | SRAM word address |
| sramWdata | output | 2*BEAT_W | SRAM write word |
| sramRdata | input | 2*BEAT_W | SRAM read word, valid one cycle after sramRe |
| fillValid | input | 1 | Level-one fill or write notification |
| fillLine | input | LINE_AW | Line named by the notification |

## Verification
The bench builds the port with its defaults: 32-bit beats, 8-bit line addresses, a four-entry history and a two-word fetch buffer. With four history slots, one eight-beat read of four fresh lines fills the table, and a second read of four other lines evicts all of them, so replacement order is visible after two bursts. The two-word buffer combined with a DMA side that stalls one cycle in three brings fetch-ahead against a full buffer into play. A dirty level-one line and a notification between bursts exercise the re-snoop path and the write-back path.

// File: rtl/dma_snoop_pkg.sv
package dma_snoop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RISSUE,
    ST_RSNP,
    ST_RRD,
    ST_WISSUE,
    ST_WSNP,
    ST_WLO,
    ST_WHI
  } portState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic histInsert;
    logic wbFromSnoop;
    logic pushSnoop;
    logic pushSram;
    logic capLow;
  } dpStrobes_t;

endpackage

// File: rtl/dma_snoop_hist.sv
module dma_snoop_hist #(
  parameter int LINE_AW = 8,
  parameter int HIST_N  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINE_AW-1:0] lookLine,
  output logic               hit,
  input  logic               insValid,
  input  logic [LINE_AW-1:0] insLine,
  input  logic               clrValid,
  input  logic [LINE_AW-1:0] clrLine
);
  localparam int PW = (HIST_N > 1) ? $clog2(HIST_N) : 1;

  logic [LINE_AW-1:0] tagQ [HIST_N];
  logic [HIST_N-1:0]  vldQ, vldD, lookHit;
  logic [PW-1:0]      ptrQ;

  genvar gi;
  generate
    for (gi = 0; gi < HIST_N; gi++) begin : g_look
      assign lookHit[gi] = vldQ[gi] && (tagQ[gi] == lookLine);
    end
  endgenerate
  assign hit = |lookHit;

  // insertion first, then a matching notification clears the slot
  always_comb begin
    vldD = vldQ;
    if (insValid) vldD[ptrQ] = 1'b1;
    for (int i = 0; i < HIST_N; i++) begin
      if (clrValid && vldD[i] &&
          (((insValid && ptrQ == PW'(i)) ? insLine : tagQ[i]) == clrLine))
        vldD[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ <= '0;
      ptrQ <= '0;
    end else begin
      vldQ <= vldD;
      if (insValid) ptrQ <= (ptrQ == PW'(HIST_N-1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (insValid) tagQ[ptrQ] <= insLine;
  end
endmodule

// File: rtl/dma_snoop_dp.sv
module dma_snoop_dp
  import dma_snoop_pkg::*;
#(
  parameter int BEAT_W  = 32,
  parameter int LINE_AW = 8,
  parameter int HIST_N  = 4,
  parameter int BUF_N   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          stb,
  input  logic [LINE_AW-1:0]  curLine,
  input  logic                fillValid,
  input  logic [LINE_AW-1:0]  fillLine,
  input  logic [2*BEAT_W-1:0] snpData,
  input  logic [2*BEAT_W-1:0] sramRdata,
  input  logic [BEAT_W-1:0]   wrData,
  input  logic                rdReady,
  output logic                histHit,
  output logic                bufFull,
  output logic                bufEmpty,
  output logic                rdValid,
  output logic [BEAT_W-1:0]   rdData,
  output logic [2*BEAT_W-1:0] sramWdata
);
  localparam int WORD_W = 2 * BEAT_W;
  localparam int PW     = (BUF_N > 1) ? $clog2(BUF_N) : 1;
  localparam int CW     = $clog2(BUF_N + 1);

  logic [WORD_W-1:0] bufMem [BUF_N];
  logic [PW-1:0]     wPtr, rPtr;
  logic [CW-1:0]     cnt;
  logic              halfQ;
  logic [BEAT_W-1:0] lowQ;
  logic              push, pop;
  logic [WORD_W-1:0] pushWord;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(BUF_N-1)) ? '0 : p + 1'b1;
  endfunction

  assign push     = stb.pushSnoop | stb.pushSram;
  assign pushWord = stb.pushSnoop ? snpData : sramRdata;
  assign rdValid  = (cnt != '0);
  assign rdData   = halfQ ? bufMem[rPtr][WORD_W-1:BEAT_W] : bufMem[rPtr][BEAT_W-1:0];
  assign pop      = rdValid && rdReady && halfQ;
  assign bufFull  = (cnt == CW'(BUF_N));
  assign bufEmpty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      cnt   <= '0;
      halfQ <= 1'b0;
    end else begin
      if (push) wPtr <= bump(wPtr);
      if (pop)  rPtr <= bump(rPtr);
      if (rdValid && rdReady) halfQ <= ~halfQ;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push)       bufMem[wPtr] <= pushWord;
    if (stb.capLow) lowQ <= wrData;
  end

  assign sramWdata = stb.wbFromSnoop ? snpData : {wrData, lowQ};

  dma_snoop_hist #(.LINE_AW(LINE_AW), .HIST_N(HIST_N)) u_hist (
    .clk      (clk),
    .rstN     (rstN),
    .lookLine (curLine),
    .hit      (histHit),
    .insValid (stb.histInsert),
    .insLine  (curLine),
    .clrValid (fillValid),
    .clrLine  (fillLine)
  );
endmodule

// File: rtl/dma_snoop_ctrl.sv
module dma_snoop_ctrl
  import dma_snoop_pkg::*;
#(
  parameter int LINE_AW  = 8,
  parameter int RD_LINES = 4,
  parameter int WR_LINES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [LINE_AW-1:0] reqLine,
  output logic               reqReady,
  input  logic               histHit,
  input  logic               bufFull,
  input  logic               bufEmpty,
  input  logic               snpDirty,
  input  logic               wrValid,
  output logic               wrReady,
  output logic               snpValid,
  output logic               sramRe,
  output logic               sramWe,
  output logic [LINE_AW-1:0] curLine,
  output dpStrobes_t         stb
);
  localparam int MAXL = (RD_LINES > WR_LINES) ? RD_LINES : WR_LINES;
  localparam int IW   = (MAXL > 1) ? $clog2(MAXL) : 1;

  portState_t         stQ, stD;
  logic [LINE_AW-1:0] baseQ;
  logic [IW-1:0]      idxQ;
  logic               adv, lastLine;

  assign curLine = baseQ + LINE_AW'(idxQ);

  always_comb begin
    stD      = stQ;
    stb      = '0;
    adv      = 1'b0;
    lastLine = 1'b0;
    reqReady = 1'b0;
    wrReady  = 1'b0;
    snpValid = 1'b0;
    sramRe   = 1'b0;
    sramWe   = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        reqReady = bufEmpty;
        if (reqValid && bufEmpty) stD = reqWrite ? ST_WISSUE : ST_RISSUE;
      end
      ST_RISSUE: if (!bufFull) begin
        if (histHit) begin sramRe = 1'b1; stD = ST_RRD; end
        else begin snpValid = 1'b1; stD = ST_RSNP; end
      end
      ST_RSNP: begin
        stb.histInsert = 1'b1;
        if (snpDirty) begin
          stb.pushSnoop   = 1'b1;
          stb.wbFromSnoop = 1'b1;
          sramWe          = 1'b1;
          adv             = 1'b1;
        end else begin
          sramRe = 1'b1;
          stD    = ST_RRD;
        end
      end
      ST_RRD: begin
        stb.pushSram = 1'b1;
        adv          = 1'b1;
      end
      ST_WISSUE: begin
        if (histHit) stD = ST_WLO;
        else begin snpValid = 1'b1; stD = ST_WSNP; end
      end
      ST_WSNP: begin
        stb.histInsert = 1'b1;
        stD            = ST_WLO;
      end
      ST_WLO: begin
        wrReady = 1'b1;
        if (wrValid) begin stb.capLow = 1'b1; stD = ST_WHI; end
      end
      ST_WHI: begin
        wrReady = 1'b1;
        if (wrValid) begin sramWe = 1'b1; adv = 1'b1; end
      end
      default: stD = ST_IDLE;
    endcase
    if (adv) begin
      if (stQ == ST_WHI) begin
        lastLine = (idxQ == IW'(WR_LINES-1));
        stD      = lastLine ? ST_IDLE : ST_WISSUE;
      end else begin
        lastLine = (idxQ == IW'(RD_LINES-1));
        stD      = lastLine ? ST_IDLE : ST_RISSUE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      baseQ <= '0;
      idxQ  <= '0;
    end else begin
      stQ <= stD;
      if (stQ == ST_IDLE && reqValid && bufEmpty) begin
        baseQ <= reqLine;
        idxQ  <= '0;
      end else if (adv && !lastLine) begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_snoop_port.sv
module dma_snoop_port
  import dma_snoop_pkg::*;
#(
  parameter int BEAT_W   = 32,
  parameter int LINE_AW  = 8,
  parameter int HIST_N   = 4,
  parameter int BUF_N    = 2,
  parameter int RD_BEATS = 8,
  parameter int WR_BEATS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [LINE_AW-1:0]  reqLine,
  output logic                reqReady,
  output logic                rdValid,
  output logic [BEAT_W-1:0]   rdData,
  input  logic                rdReady,
  input  logic                wrValid,
  input  logic [BEAT_W-1:0]   wrData,
  output logic                wrReady,
  output logic                snpValid,
  output logic [LINE_AW-1:0]  snpLine,
  input  logic                snpDirty,
  input  logic [2*BEAT_W-1:0] snpData,
  output logic                sramRe,
  output logic                sramWe,
  output logic [LINE_AW-1:0]  sramAddr,
  output logic [2*BEAT_W-1:0] sramWdata,
  input  logic [2*BEAT_W-1:0] sramRdata,
  input  logic                fillValid,
  input  logic [LINE_AW-1:0]  fillLine
);
  localparam int RD_LINES = RD_BEATS / 2;
  localparam int WR_LINES = WR_BEATS / 2;

  dpStrobes_t         stb;
  logic [LINE_AW-1:0] curLine;
  logic               histHit, bufFull, bufEmpty;

  assign snpLine  = curLine;
  assign sramAddr = curLine;

  dma_snoop_ctrl #(.LINE_AW(LINE_AW), .RD_LINES(RD_LINES), .WR_LINES(WR_LINES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqLine  (reqLine),
    .reqReady (reqReady),
    .histHit  (histHit),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .snpDirty (snpDirty),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .snpValid (snpValid),
    .sramRe   (sramRe),
    .sramWe   (sramWe),
    .curLine  (curLine),
    .stb      (stb)
  );

  dma_snoop_dp #(.BEAT_W(BEAT_W), .LINE_AW(LINE_AW), .HIST_N(HIST_N), .BUF_N(BUF_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .curLine   (curLine),
    .fillValid (fillValid),
    .fillLine  (fillLine),
    .snpData   (snpData),
    .sramRdata (sramRdata),
    .wrData    (wrData),
    .rdReady   (rdReady),
    .histHit   (histHit),
    .bufFull   (bufFull),
    .bufEmpty  (bufEmpty),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .sramWdata (sramWdata)
  );
endmodule

// File: rtl/dma_snoop_port_chk.sv
module dma_snoop_port_chk #(
  parameter int BEAT_W  = 32,
  parameter int LINE_AW = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqWrite,
  input logic               reqReady,
  input logic               rdValid,
  input logic [BEAT_W-1:0]  rdData,
  input logic               rdReady,
  input logic               wrValid,
  input logic               wrReady,
  input logic               snpValid,
  input logic [LINE_AW-1:0] snpLine,
  input logic               snpDirty,
  input logic               sramRe,
  input logic               sramWe,
  input logic [LINE_AW-1:0] sramAddr
);
  logic burstWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) burstWrQ <= 1'b0;
    else if (reqValid && reqReady) burstWrQ <= reqWrite;
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdData));

  // R9
  snoop_before_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && burstWrQ |=> !sramWe && !wrReady);

  // R7
  dirty_writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && !burstWrQ |=> (!snpDirty || (sramWe && !sramRe && sramAddr == $past(snpLine))));

  // R8
  single_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sramRe && sramWe));

  // R4
  snoop_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> !sramRe && !sramWe);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rdValid && !wrReady && !snpValid);

  // R3
  merged_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramWe && burstWrQ |-> wrValid && wrReady);
endmodule

bind dma_snoop_port dma_snoop_port_chk #(.BEAT_W(BEAT_W), .LINE_AW(LINE_AW)) u_chk (.*);

// File: tb/dma_snoop_port_tb.sv
module dma_snoop_port_tb;
  localparam int BW = 32;
  localparam int AW = 8;
  localparam int WW = 64;
  localparam int NL = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, reqValid, reqWrite, reqReady;
  logic [AW-1:0] reqLine, snpLine, sramAddr, fillLine;
  logic          rdValid, rdReady, wrValid, wrReady;
  logic [BW-1:0] rdData, wrData;
  logic          snpValid, snpDirty, sramRe, sramWe, fillValid;
  logic [WW-1:0] snpData, sramWdata, sramRdata;

  dma_snoop_port u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqLine(reqLine),
    .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData), .rdReady(rdReady),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady), .snpValid(snpValid),
    .snpLine(snpLine), .snpDirty(snpDirty), .snpData(snpData), .sramRe(sramRe),
    .sramWe(sramWe), .sramAddr(sramAddr), .sramWdata(sramWdata), .sramRdata(sramRdata),
    .fillValid(fillValid), .fillLine(fillLine)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stallMode = 0;
  int gapMode = 0;

  logic [WW-1:0] mem [NL];
  logic [WW-1:0] refMem [NL];
  logic [WW-1:0] l1Data [NL];
  logic          l1Dirty [NL];
  int nRd = 0, nWr = 0;

  logic [BW-1:0] expQ [$];
  logic [BW-1:0] wrQ [$];
  int            expSnp [$];
  int            histA [$];
  bit            histV [$];
  int            snpInBurst = 0;
  int            snpSeenCyc = 0;
  bit            wrNeedSnoop = 0;
  bit            holdPend = 0;
  logic [BW-1:0] holdData;

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [WW-1:0] lineWord(int l);
    return {32'h5A00_0000 + 32'(2*l+1), 32'h5A00_0000 + 32'(2*l)};
  endfunction

  function automatic bit refHit(int line);
    for (int i = 0; i < histA.size(); i++)
      if (histV[i] && histA[i] == line) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void refInsert(int line);
    histA.push_back(line);
    histV.push_back(1'b1);
    if (histA.size() > 4) begin
      void'(histA.pop_front());
      void'(histV.pop_front());
    end
  endfunction

  function automatic void refClear(int line);
    for (int i = 0; i < histA.size(); i++)
      if (histA[i] == line) histV[i] = 1'b0;
  endfunction

  // memory and level-one models
  always @(posedge clk) begin
    if (sramRe) begin sramRdata <= mem[sramAddr]; nRd <= nRd + 1; end
    if (sramWe) begin mem[sramAddr] <= sramWdata; nWr <= nWr + 1; end
    if (snpValid) begin
      snpDirty <= l1Dirty[snpLine];
      snpData  <= l1Data[snpLine];
      l1Dirty[snpLine] <= 1'b0;
    end
  end

  // per-clock driver and comparison against the reference queues
  always @(negedge clk) begin
    cyc++;
    rdReady = (stallMode == 0) ? 1'b1 : (cyc % 3 != 0);
    if (wrQ.size() > 0 && (gapMode == 0 || cyc % 2 == 0)) begin
      wrValid = 1'b1;
      wrData  = wrQ[0];
    end else begin
      wrValid = 1'b0;
    end
    if (rstN) begin
      if (holdPend)
        check(rdValid && rdData == holdData, "R10", "stalled beat held", longint'(rdData), longint'(holdData));
      holdPend = rdValid && !rdReady;
      holdData = rdData;
      if (wrReady && wrNeedSnoop) begin
        check(snpInBurst > 0 && snpSeenCyc < cyc, "R9", "write beat before snoop", snpInBurst, 1);
        wrNeedSnoop = 1'b0;
      end
      if (wrValid && wrReady) void'(wrQ.pop_front());
      if (rdValid && rdReady) begin
        if (expQ.size() == 0) check(1'b0, "R2", "extra read beat", longint'(rdData), 0);
        else begin
          check(rdData == expQ[0], "R2", "read beat data", longint'(rdData), longint'(expQ[0]));
          void'(expQ.pop_front());
        end
      end
      if (snpValid) begin
        snpInBurst++;
        snpSeenCyc = cyc;
        if (expSnp.size() == 0) check(1'b0, "R4", "unexpected snoop", snpLine, 0);
        else begin
          check(snpLine == expSnp[0], "R4", "snoop line", snpLine, expSnp[0]);
          void'(expSnp.pop_front());
        end
      end
    end
  end

  task automatic sendReq(int line, bit wr);
    @(negedge clk);
    reqValid = 1'b1;
    reqLine  = AW'(line);
    reqWrite = wr;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R11", "busy after accept", reqReady, 0);
  endtask

  task automatic notifyL1(int line, logic [WW-1:0] data, bit dirty);
    @(negedge clk);
    fillValid = 1'b1;
    fillLine  = AW'(line);
    l1Data[line]  <= data;
    l1Dirty[line] <= dirty;
    refClear(line);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic readBurst(int base, int stall, int expSnoops, string snpReq);
    int r0, w0, want;
    logic [WW-1:0] w;
    want = 0;
    for (int l = 0; l < 4; l++) begin
      if (l1Dirty[base+l]) begin
        w = l1Data[base+l];
        refMem[base+l] = w;
      end else w = refMem[base+l];
      expQ.push_back(w[31:0]);
      expQ.push_back(w[63:32]);
      if (!refHit(base+l)) begin
        expSnp.push_back(base+l);
        refInsert(base+l);
        want++;
      end
    end
    check(want == expSnoops, snpReq, "planned snoop count", want, expSnoops);
    stallMode  = stall;
    snpInBurst = 0;
    r0 = nRd;
    w0 = nWr;
    sendReq(base, 1'b0);
    while (expQ.size() != 0 || !reqReady) @(negedge clk);
    check(snpInBurst == expSnoops, snpReq, "snoops in read burst", snpInBurst, expSnoops);
    check(expSnp.size() == 0, "R4", "missing snoops", expSnp.size(), 0);
    expSnp.delete();
    check((nRd - r0) + (nWr - w0) == 4, "R8", "bank accesses in read burst", (nRd - r0) + (nWr - w0), 4);
    for (int l = 0; l < 4; l++)
      check(mem[base+l] == refMem[base+l], "R7", "sram line after read", longint'(mem[base+l]), longint'(refMem[base+l]));
    stallMode = 0;
  endtask

  task automatic writeBurst(int base, int gap, int seed, int expSnoops);
    int r0, w0, want;
    logic [BW-1:0] b [4];
    want = 0;
    for (int k = 0; k < 4; k++) b[k] = 32'hC0DE_0000 + 32'(seed * 16 + k);
    wrNeedSnoop = !refHit(base);
    for (int l = 0; l < 2; l++) begin
      refMem[base+l] = {b[2*l+1], b[2*l]};
      if (!refHit(base+l)) begin
        expSnp.push_back(base+l);
        refInsert(base+l);
        want++;
      end
    end
    check(want == expSnoops, "R4", "planned write snoops", want, expSnoops);
    for (int k = 0; k < 4; k++) wrQ.push_back(b[k]);
    gapMode    = gap;
    snpInBurst = 0;
    r0 = nRd;
    w0 = nWr;
    sendReq(base, 1'b1);
    while (wrQ.size() != 0 || !reqReady) @(negedge clk);
    check(snpInBurst == expSnoops, "R4", "snoops in write burst", snpInBurst, expSnoops);
    check(nWr - w0 == 2, "R3", "merged sram writes", nWr - w0, 2);
    check(nRd - r0 == 0, "R3", "sram reads in write burst", nRd - r0, 0);
    for (int l = 0; l < 2; l++)
      check(mem[base+l] == refMem[base+l], "R3", "written line", longint'(mem[base+l]), longint'(refMem[base+l]));
    expSnp.delete();
    wrNeedSnoop = 1'b0;
    gapMode = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqLine = '0;
    rdReady = 1'b1; wrValid = 1'b0; wrData = '0; fillValid = 1'b0; fillLine = '0;
    snpDirty = 1'b0; snpData = '0; sramRdata = '0;
    for (int l = 0; l < NL; l++) begin
      mem[l]     <= lineWord(l);
      refMem[l]   = lineWord(l);
      l1Data[l]  <= '0;
      l1Dirty[l] <= 1'b0;
    end
    repeat (3) @(negedge clk);
    check(reqReady && !rdValid && !wrReady && !snpValid && !sramRe && !sramWe,
          "R1", "outputs in reset", {reqReady, rdValid, wrReady, snpValid, sramRe, sramWe}, 6'b100000);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rdValid && !wrReady && !snpValid && !sramRe && !sramWe,
          "R1", "outputs after reset", {reqReady, rdValid, wrReady, snpValid, sramRe, sramWe}, 6'b100000);

    // R2 R4: fresh lines, every line snooped
    readBurst(0, 0, 4, "R4");
    // R4: all four lines recorded, no snoop
    readBurst(0, 0, 0, "R4");
    // R6 R7: level-one writes line 1, notification clears its record
    notifyL1(1, 64'hDEAD_BEEF_1234_5678, 1'b1);
    readBurst(0, 0, 1, "R6");
    // R10: stalling DMA side on new lines
    readBurst(4, 1, 4, "R10");
    // R5: lines 0..3 evicted by 4..7
    readBurst(0, 1, 4, "R5");
    // R3 R9: dirty level-one copy on a written line is discarded
    notifyL1(8, 64'h1111_2222_3333_4444, 1'b1);
    writeBurst(8, 0, 1, 2);
    readBurst(8, 0, 2, "R4");
    // R3: recorded lines, gaps on the write beats
    writeBurst(8, 1, 2, 0);
    readBurst(8, 1, 0, "R5");
    // R6: plain fill without dirt forces one snoop
    notifyL1(10, 64'h0, 1'b0);
    readBurst(8, 0, 1, "R6");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule